// File: doc/BRIEF.md
# Two-Wire Serial Bus Shift Node

This block is an eight-bit shift register node for a two-wire, open-drain serial bus, with one clock wire and one data wire. Software reaches it through a small register port. Writing the data register loads the byte to transmit and arms a transfer. Reading the data register returns the shift register at any time. A control register selects the following:

- the enable bit;
- wake-up (address-match) mode;
- whether the node makes the serial clock itself (master) or follows the clock on the wire (slave).

The node pulls the data wire low through an open-drain output and, in master mode, pulls the clock wire low in the same way. Bits leave most-significant first. The output bit changes on the falling clock edge and the input is sampled on the rising edge. After eight rising edges the transfer stops by itself and may raise the interrupt flag.

A bus-release detector watches for the data wire rising while the clock wire is high. The first byte received after such a release is compared with a programmable node address. In wake-up mode the data pull-down stays off. Only a matching first byte after a release raises the interrupt; any other byte is discarded. A busy-hold output can be raised by software. A release request lowers it only at the next falling clock edge. A transfer armed while busy waits until busy is gone and the data wire reads high.

Top module: `sbus_node`

## Requirements
- R1: After reset the data register reads 00h, the status register reads 00h, and `sda_pull`, `sck_pull`, `busy_hold` and `irq` are all 0.
- R2: A write to the data register (address 0) while enable (control bit 0) is 1 starts a transfer. A write made while enable is 0 loads the data but never starts a transfer, even after enable is later set.
- R3: Control bit 2 selects master mode. In master mode the node drives eight clock pulses only while a transfer is active. The byte appears on the data wire MSB first, changing after falling edges and sampled at rising edges, so with the pull-down active the node receives back its own byte.
- R4: When eight bits have been shifted, status bit 3 (active) clears. With wake-up off, status bit 7 and `irq` become 1 and stay 1 until command bit 2 (address 3) is written.
- R5: With control bit 1 (wake-up) at 0, `sda_pull` follows the current output bit, so a received byte is the wired-AND of the line and the preloaded data. With wake-up at 1, `sda_pull` is never asserted.
- R6: A data write made while `busy_hold` is 1 is kept. Its transfer starts only after busy has cleared and the data wire reads high.
- R7: Command bit 0 raises `busy_hold`. Command bit 1 lowers it only at the next falling edge of the clock wire. Writing the control register, including setting wake-up, does not lower it.
- R8: The data wire rising while the clock wire is high and no transfer is active sets the release flag (status bit 5). The flag clears when the next byte completes or when command bit 3 is written.
- R9: In wake-up mode, a byte completed while the release flag is set and equal to the node address (address 2) sets `irq` and the match flag (status bit 6). Any other completed byte leaves `irq` at 0 and the data register reads FFh.
- R10: Data-register writes made while a transfer is active are ignored; they neither change the byte being shifted nor arm another transfer.
- R11: In slave mode an armed transfer waits while the clock wire is low and starts once it reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 data, 1 control/status, 2 node address, 3 command |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for the selected register |
| sck_in | input | 1 | Level of the clock wire |
| sck_pull | output | 1 | Pulls the clock wire low (master mode) |
| sda_in | input | 1 | Level of the data wire |
| sda_pull | output | 1 | Pulls the data wire low |
| busy_hold | output | 1 | Busy indication held by software |
| irq | output | 1 | Completion or address-match interrupt flag |

## Verification
The hardest case to reach is a transfer armed while busy, which must survive both the busy release and the later falling clock edge and then wait for the data wire to go high. The bench reaches it by acting as the remote bus master. It holds the data wire low and raises busy, writes the data register, and requests release. It then gives one clock fall so that busy lowers. The data wire is raised only after that, and the bench confirms that nothing starts before the line goes high. The address-match cases are reached the same way: the bench drives release conditions and bytes on the wires itself.

// File: rtl/sbus_pkg.sv
// Package: register map, command bits and status bit positions shared by
// the serial bus node and its helpers. Assumes an 8-bit or wider data path.
package sbus_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_NODE = 2'd2,
        REG_CMD  = 2'd3
    } sbus_reg_e;

    // control register bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_WAKE   = 1;
    localparam int CTL_MASTER = 2;

    // command register bit positions (write-only strobes)
    localparam int CMD_BUSY_SET = 0;
    localparam int CMD_BUSY_REL = 1;
    localparam int CMD_IRQ_CLR  = 2;
    localparam int CMD_REL_CLR  = 3;

    // status register bit positions
    localparam int ST_EN     = 0;
    localparam int ST_WAKE   = 1;
    localparam int ST_MASTER = 2;
    localparam int ST_ACTIVE = 3;
    localparam int ST_BUSY   = 4;
    localparam int ST_REL    = 5;
    localparam int ST_HIT    = 6;
    localparam int ST_IRQ    = 7;

endpackage

// File: rtl/sbus_clkgen.sv
// Module: internal serial clock generator for master mode.
// Produces a clock that idles high and toggles every HALF_PERIOD system
// clocks while run is high. Assumes run drops right after the final rising
// edge, so the clock is left high.
module sbus_clkgen #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_o
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    // Divide the system clock into serial clock half periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_o <= 1'b1;
        end else if (!run) begin
            cnt   <= '0;
            sck_o <= 1'b1;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            sck_o <= ~sck_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sbus_shift.sv
// Module: shift register and bit sequencer.
// Holds the byte, presents the MSB on out_bit at falling clock edges,
// shifts the sampled wire in at rising edges and flags done on the last one.
// Assumes rise/fall are single-cycle pulses. keep is decided by the parent
// from rx_byte in the same cycle as done; when low, FFh is stored.
module sbus_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          go,
    input  logic          abort,
    input  logic          rise,
    input  logic          fall,
    input  logic          sda_bit,
    input  logic          keep,
    output logic [DW-1:0] sr,
    output logic [DW-1:0] rx_byte,
    output logic          out_bit,
    output logic          active,
    output logic          done
);
    localparam int NW = $clog2(DW + 1);
    localparam logic [NW-1:0] LAST_BIT = NW'(DW - 1);

    logic [NW-1:0] bit_cnt;

    assign rx_byte = {sr[DW-2:0], sda_bit};
    assign done    = active && rise && (bit_cnt == LAST_BIT);

    // Load, launch, shift and finish the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            out_bit <= 1'b1;
            active  <= 1'b0;
            bit_cnt <= '0;
        end else if (abort && active) begin
            active  <= 1'b0;
            out_bit <= 1'b1;
            bit_cnt <= '0;
        end else if (ld && !active) begin
            sr <= ld_data;
        end else if (go && !active) begin
            active  <= 1'b1;
            bit_cnt <= '0;
            out_bit <= sr[DW-1];
        end else if (active) begin
            if (fall) begin
                out_bit <= sr[DW-1];
            end
            if (rise) begin
                if (bit_cnt == LAST_BIT) begin
                    active  <= 1'b0;
                    out_bit <= 1'b1;
                    bit_cnt <= '0;
                    sr      <= keep ? rx_byte : '1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    sr      <= rx_byte;
                end
            end
        end
    end
endmodule

// File: rtl/sbus_busctl.sv
// Module: bus-release detector and busy-hold control.
// Release: data wire rises while the clock wire is high and the node is
// idle. Busy: raised by command and lowered at the first falling clock edge
// after a release request. Assumes all inputs are synchronous to clk.
module sbus_busctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_now,
    input  logic sck_now,
    input  logic fall,
    input  logic active,
    input  logic busy_set,
    input  logic busy_rel,
    input  logic rel_clr,
    input  logic byte_done,
    output logic busy,
    output logic rel_flag
);
    logic sda_d;
    logic rel_req;
    logic rel_seen;

    assign rel_seen = sda_now && !sda_d && sck_now && !active;

    // Remember the previous data wire level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= sda_now;
    end

    // Track the release flag from detection until the next byte or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rel_flag <= 1'b0;
        else if (rel_seen)              rel_flag <= 1'b1;
        else if (byte_done || rel_clr)  rel_flag <= 1'b0;
    end

    // Raise busy on command; drop it at the falling edge after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rel_req <= 1'b0;
        end else if (busy_set) begin
            busy    <= 1'b1;
            rel_req <= 1'b0;
        end else if (busy_rel && busy) begin
            rel_req <= 1'b1;
        end else if (rel_req && fall) begin
            busy    <= 1'b0;
            rel_req <= 1'b0;
        end
    end
endmodule

// File: rtl/sbus_node.sv
// Module: top of the two-wire serial bus shift node.
// Register port, transfer start gating, clock selection, address match and
// interrupt flag. Assumes sck_in/sda_in are the resolved wire levels; they
// are registered once before use. Status needs DW >= 8.
module sbus_node
    import sbus_pkg::*;
#(
    parameter int DW          = 8,
    parameter int HALF_PERIOD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          sck_in,
    output logic          sck_pull,
    input  logic          sda_in,
    output logic          sda_pull,
    output logic          busy_hold,
    output logic          irq
);
    logic          en_q, wake_q, master_q;
    logic [DW-1:0] node_q;
    logic          irq_q, hit_q;
    logic          pend, pend_hold;
    logic          sck_s, sda_s, sck_d;
    logic          sck_int, sck_now, sck_rise, sck_fall;
    logic          wr_data, wr_ctrl, wr_node, wr_cmd;
    logic          go, idle, keep, hit;
    logic          active, done, out_bit, rel_flag;
    logic [DW-1:0] sr, rx_byte;
    logic [DW-1:0] status;

    assign wr_data = cpu_we && (cpu_addr == REG_DATA);
    assign wr_ctrl = cpu_we && (cpu_addr == REG_CTRL);
    assign wr_node = cpu_we && (cpu_addr == REG_NODE);
    assign wr_cmd  = cpu_we && (cpu_addr == REG_CMD);

    // Register the wire levels once before they are used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= 1'b1;
            sda_s <= 1'b1;
        end else begin
            sck_s <= sck_in;
            sda_s <= sda_in;
        end
    end

    assign sck_now = master_q ? sck_int : sck_s;

    // Keep the previous effective clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b1;
        else        sck_d <= sck_now;
    end

    assign sck_rise = !sck_d && sck_now;
    assign sck_fall = sck_d && !sck_now;

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            wake_q   <= 1'b0;
            master_q <= 1'b0;
            node_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q     <= cpu_wdata[CTL_EN];
                wake_q   <= cpu_wdata[CTL_WAKE];
                master_q <= cpu_wdata[CTL_MASTER];
            end
            if (wr_node) node_q <= cpu_wdata;
        end
    end

    // Arm a transfer on a data write while enabled; drop it when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_hold <= 1'b0;
        end else if (!en_q) begin
            pend      <= 1'b0;
            pend_hold <= 1'b0;
        end else if (wr_data && !active) begin
            pend      <= 1'b1;
            pend_hold <= busy_hold;
        end else if (go) begin
            pend      <= 1'b0;
            pend_hold <= 1'b0;
        end
    end

    assign idle = master_q ? 1'b1 : sck_s;
    assign go   = pend && en_q && !active && idle && !busy_hold
                  && (!pend_hold || sda_s);

    assign hit  = wake_q && rel_flag && (rx_byte == node_q);
    assign keep = !wake_q || hit;

    // Interrupt and match flags: set at completion, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            hit_q <= 1'b0;
        end else if (done && keep) begin
            irq_q <= 1'b1;
            hit_q <= hit;
        end else if (wr_cmd && cpu_wdata[CMD_IRQ_CLR]) begin
            irq_q <= 1'b0;
            hit_q <= 1'b0;
        end
    end

    sbus_clkgen #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active && master_q),
        .sck_o (sck_int)
    );

    sbus_shift #(
        .DW(DW)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (wr_data),
        .ld_data (cpu_wdata),
        .go      (go),
        .abort   (!en_q),
        .rise    (sck_rise),
        .fall    (sck_fall),
        .sda_bit (sda_s),
        .keep    (keep),
        .sr      (sr),
        .rx_byte (rx_byte),
        .out_bit (out_bit),
        .active  (active),
        .done    (done)
    );

    sbus_busctl u_busctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_now   (sda_s),
        .sck_now   (sck_now),
        .fall      (sck_fall),
        .active    (active),
        .busy_set  (wr_cmd && cpu_wdata[CMD_BUSY_SET]),
        .busy_rel  (wr_cmd && cpu_wdata[CMD_BUSY_REL]),
        .rel_clr   (wr_cmd && cpu_wdata[CMD_REL_CLR]),
        .byte_done (done),
        .busy      (busy_hold),
        .rel_flag  (rel_flag)
    );

    // Assemble the status word.
    always_comb begin
        status            = '0;
        status[ST_EN]     = en_q;
        status[ST_WAKE]   = wake_q;
        status[ST_MASTER] = master_q;
        status[ST_ACTIVE] = active;
        status[ST_BUSY]   = busy_hold;
        status[ST_REL]    = rel_flag;
        status[ST_HIT]    = hit_q;
        status[ST_IRQ]    = irq_q;
    end

    // Read multiplexer for the register port.
    always_comb begin
        case (cpu_addr)
            REG_DATA: cpu_rdata = sr;
            REG_CTRL: cpu_rdata = status;
            REG_NODE: cpu_rdata = node_q;
            default:  cpu_rdata = '0;
        endcase
    end

    assign sda_pull = en_q && !wake_q && !out_bit;
    assign sck_pull = master_q && !sck_int;
    assign irq      = irq_q;
endmodule

// File: rtl/sbus_node_chk.sv
// Module: assertion checker bound to sbus_node.
// Observes ports and internal control signals; drives nothing.
module sbus_node_chk (
    input logic clk,
    input logic rst_n,
    input logic en_q,
    input logic wake_q,
    input logic active,
    input logic done,
    input logic sck_fall,
    input logic sda_pull,
    input logic sck_pull,
    input logic busy_hold,
    input logic irq
);
    // R5
    wake_pull_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> !sda_pull);

    // R7
    busy_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_hold) |-> $past(sck_fall));

    // R4
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wake_q) |=> irq);

    // R2
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(en_q));

    // R3
    clock_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_pull |-> active);
endmodule

bind sbus_node sbus_node_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .wake_q    (wake_q),
    .active    (active),
    .done      (done),
    .sck_fall  (sck_fall),
    .sda_pull  (sda_pull),
    .sck_pull  (sck_pull),
    .busy_hold (busy_hold),
    .irq       (irq)
);

// File: tb/sim_sbus_node.sv
module sim_sbus_node;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       sck_in, sck_pull, sda_in, sda_pull, busy_hold, irq;
    logic       b_sck = 1'b1;
    logic       b_sda = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // monitor state
    logic       mon = 1'b0;
    logic       sck_p = 1'b1;
    logic       pull_p = 1'b0;
    logic [7:0] cap = 8'd0;
    int         pulls = 0;

    always #2 clk = ~clk;

    assign sck_in = b_sck & ~sck_pull;
    assign sda_in = b_sda & ~sda_pull;

    sbus_node u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sck_in(sck_in),
        .sck_pull(sck_pull), .sda_in(sda_in), .sda_pull(sda_pull),
        .busy_hold(busy_hold), .irq(irq)
    );

    // Record data wire bits at each rising clock wire edge, count clock pulls.
    always @(negedge clk) begin
        if (mon && !sck_p && sck_in) cap <= {cap[6:0], sda_in};
        if (sck_pull && !pull_p) pulls <= pulls + 1;
        sck_p  <= sck_in;
        pull_p <= sck_pull;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a;
        #1 v = cpu_rdata;
    endtask

    task automatic idle_wait();
        logic [7:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(2'd1, s);
            if (!s[3]) break;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Act as the remote bus master sending one byte, MSB first.
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            b_sck = 1'b0; cyc(4);
            b_sda = b[i]; cyc(4);
            b_sck = 1'b1; cyc(6);
        end
        b_sck = 1'b0; cyc(3);
        b_sda = 1'b1; cyc(3);
        b_sck = 1'b1; cyc(4);
    endtask

    task automatic bus_release();
        b_sda = 1'b0; cyc(4);
        b_sda = 1'b1; cyc(4);
    endtask

    // {wake, data, expected received byte} for master loopback transfers
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 8'hA5, 8'hA5},
        {1'b0, 8'h01, 8'h01},
        {1'b0, 8'h80, 8'h80},
        {1'b0, 8'h3C, 8'h3C},
        {1'b1, 8'h00, 8'hFF},
        {1'b1, 8'h5A, 8'hFF}
    };

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 data", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 pins", {4'd0, sda_pull, sck_pull, busy_hold, irq}, 8'h00);

        // R3/R4/R5 master loopback table
        for (int k = 0; k < 6; k++) begin
            wr(2'd1, {5'd0, 1'b1, VEC[k][16], 1'b1});
            wr(2'd3, 8'h0C);
            mon = 1'b1;
            wr(2'd0, VEC[k][15:8]);
            cyc(2);
            rd(2'd1, v); chk("R2 started", v & 8'h08, 8'h08);
            idle_wait();
            cyc(2);
            mon = 1'b0;
            rd(2'd0, v); chk("R3 loopback rx", v, VEC[k][7:0]);
            chk("R3 wire MSB first", cap, VEC[k][16] ? 8'hFF : VEC[k][15:8]);
            rd(2'd1, v); chk("R4 irq status", v & 8'h88, VEC[k][16] ? 8'h00 : 8'h80);
            chk("R4 irq pin", {7'd0, irq}, {7'd0, ~VEC[k][16]});
        end
        // R4 irq stays until cleared
        wr(2'd1, 8'h05);
        wr(2'd3, 8'h0C);
        wr(2'd0, 8'h11);
        idle_wait(); cyc(20);
        chk("R4 irq held", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h04);
        chk("R4 irq cleared", {7'd0, irq}, 8'h00);

        // R10 write during active transfer ignored
        wr(2'd0, 8'hC6);
        cyc(6);
        wr(2'd0, 8'h00);
        idle_wait(); cyc(2);
        rd(2'd0, v); chk("R10 write ignored", v, 8'hC6);
        cyc(40);
        rd(2'd1, v); chk("R10 no second start", v & 8'h08, 8'h00);
        wr(2'd3, 8'h0C);

        // R2 write while disabled, then enable: no start
        wr(2'd1, 8'h04);
        wr(2'd0, 8'h3C);
        pulls = 0;
        wr(2'd1, 8'h05);
        cyc(60);
        rd(2'd1, v); chk("R2 no start after enable", v & 8'h08, 8'h00);
        chk("R2 no clock pulses", 8'(pulls), 8'd0);
        rd(2'd0, v); chk("R2 data loaded", v, 8'h3C);

        // R11 slave: waits for clock wire high
        wr(2'd1, 8'h01);
        b_sck = 1'b0; cyc(4);
        wr(2'd0, 8'hFF);
        cyc(10);
        rd(2'd1, v); chk("R11 held while clock low", v & 8'h08, 8'h00);
        b_sck = 1'b1; cyc(5);
        rd(2'd1, v); chk("R11 start on clock high", v & 8'h08, 8'h08);
        send_byte(8'hC3);
        rd(2'd0, v); chk("R11 slave rx", v, 8'hC3);
        chk("R4 slave irq", {7'd0, irq}, 8'h01);

        // R5 wake off: preloaded zeros corrupt the line
        wr(2'd3, 8'h0C);
        wr(2'd0, 8'h0F);
        cyc(3);
        send_byte(8'hA5);
        rd(2'd0, v); chk("R5 wired-AND rx", v, 8'h05);

        // R8/R9 wake-up address match
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h5A);
        wr(2'd3, 8'h0C);
        bus_release();
        rd(2'd1, v); chk("R8 release flag set", v & 8'h20, 8'h20);
        wr(2'd0, 8'h00);
        cyc(3);
        chk("R5 wake pull off", {7'd0, sda_pull}, 8'h00);
        send_byte(8'h5A);
        rd(2'd0, v); chk("R9 match rx", v, 8'h5A);
        rd(2'd1, v); chk("R9 match status irq/hit/rel", v & 8'hE0, 8'hC0);
        chk("R9 irq pin", {7'd0, irq}, 8'h01);

        // R9 mismatch after release
        wr(2'd3, 8'h0C);
        bus_release();
        wr(2'd0, 8'h00);
        cyc(3);
        send_byte(8'h33);
        rd(2'd0, v); chk("R9 mismatch discarded", v, 8'hFF);
        chk("R9 mismatch no irq", {7'd0, irq}, 8'h00);
        rd(2'd1, v); chk("R8 release flag cleared by byte", v & 8'h20, 8'h00);

        // R9 matching byte without release
        wr(2'd0, 8'h00);
        cyc(3);
        send_byte(8'h5A);
        chk("R9 no release no irq", {7'd0, irq}, 8'h00);
        rd(2'd0, v); chk("R9 no release discarded", v, 8'hFF);

        // R8 clear by command
        bus_release();
        wr(2'd3, 8'h08);
        rd(2'd1, v); chk("R8 release flag cmd clear", v & 8'h20, 8'h00);

        // R7 busy release waits for falling edge; wake does not clear it
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h01);
        chk("R7 busy raised", {7'd0, busy_hold}, 8'h01);
        wr(2'd1, 8'h03);
        cyc(5);
        chk("R7 busy kept on wake set", {7'd0, busy_hold}, 8'h01);
        wr(2'd3, 8'h02);
        cyc(10);
        chk("R7 busy kept until fall", {7'd0, busy_hold}, 8'h01);
        b_sck = 1'b0; cyc(5);
        chk("R7 busy cleared at fall", {7'd0, busy_hold}, 8'h00);
        b_sck = 1'b1; cyc(4);

        // R6 write during busy is held until busy clears and line is high
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h0D);
        b_sda = 1'b0; cyc(2);
        wr(2'd0, 8'hFF);
        cyc(8);
        rd(2'd1, v); chk("R6 held while busy", v & 8'h08, 8'h00);
        wr(2'd3, 8'h02);
        b_sck = 1'b0; cyc(5);
        b_sck = 1'b1; cyc(5);
        chk("R6 busy released", {7'd0, busy_hold}, 8'h00);
        rd(2'd1, v); chk("R6 held while line low", v & 8'h08, 8'h00);
        b_sda = 1'b1; cyc(5);
        rd(2'd1, v); chk("R6 start after line high", v & 8'h08, 8'h08);
        send_byte(8'h81);
        rd(2'd0, v); chk("R6 held transfer rx", v, 8'h81);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule